// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block keeps the interrupt status word of an SD host controller. Event logic elsewhere in the host sends single-cycle pulses on a 32-bit event vector, one line per status bit. A pulse sets its status bit only when software has enabled that bit in the status-enable register. A second per-bit register, the signal-enable register, picks which of the set bits drive the interrupt line. The latching of a bit and the signalling of it are set up apart from each other.

Software reads the status word and clears bits by writing ones to them. Writing back the word it has just read therefore clears every bit that was set. Bit 15 is a read-only summary. It is high while any error bit (bits 16 and up) is set. Bit 15 cannot be written and no event line sets it. A control register holds a software-reset bit. Setting it clears all status and both enable registers for a fixed number of cycles. The bit then clears itself, and software can poll for that.

Register access uses a plain 32-bit port with a word address, a write strobe and a combinational read path.

Top module: `sd_irq_status`

## Requirements
- R1: Normal status bits sit at positions 0 (command complete), 1 (transfer complete), 3 (DMA interrupt), 4 (buffer write ready) and 5 (buffer read ready). A pulse on event line N can set only status bit N. No other bit below 15 ever latches.
- R2: Error status bits occupy bits 16 to 19, and bit 16 is command timeout. Bit 15 of the status read value is high exactly when at least one of bits 16 to 19 is set.
- R3: Writing the status register clears every status bit where the written data holds a 1 and leaves the other bits alone. Writing back the value just read leaves the status at zero.
- R4: A status bit latches only when its bit in the status-enable register is 1 in the cycle of the pulse. Once latched, the bit stays set when its enable is later cleared.
- R5: `irqOut` is high exactly when some latched status bit has its signal-enable bit set. Signal-enable has no effect on latching.
- R6: Bit 15 cannot be cleared by a write of 1 while an error bit is set, and a pulse on event line 15 never sets it.
- R7: When a pulse and a clearing write hit the same status bit in the same cycle, and that bit is status-enabled, the bit ends up set.
- R8: Writing 1 to bit 0 of the control register starts a software reset. While it is active, the status register and both enable registers are held at zero, and event pulses and register writes are ignored.
- R9: Control bit 0 reads 1 for exactly 8 cycles after the write that set it, then reads 0 without any further write.
- R10: Word address 0 is status, 1 is status-enable, 2 is signal-enable and 3 is control. The enable registers store and read back only the implemented bits (0, 1, 3, 4, 5 and 16 to 19).
- R11: An active-low `rstN` clears status, both enables and the reset counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 32 | Single-cycle event pulses, one per status bit |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a collision: a pulse arriving in the same cycle as a ones-write to the same bit. The bench places the pulse and the clearing write on one clock edge by driving both in the same step. It also checks the software-reset window from both sides. During that window it sends pulses and enable writes and expects them to leave nothing behind. It counts the busy cycles one by one so that a window that is one cycle off is reported.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;

  localparam int REG_W   = 32;
  localparam int ADDR_W  = 2;
  localparam int SUM_BIT = 15;
  localparam int ERR_LSB = 16;

  localparam logic [ADDR_W-1:0] ADDR_STS   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STSEN = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SIGEN = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTL   = 2'd3;

  // strobes handed from control to datapath
  typedef struct packed {
    logic stsW1c;   // ones-write to status
    logic stsEnWr;  // load status-enable
    logic sigEnWr;  // load signal-enable
    logic clrAll;   // software reset active
  } ctlStrobes_t;

endpackage

// File: rtl/sd_irq_ctrl.sv
module sd_irq_ctrl
  import sd_irq_pkg::*;
#(
  parameter int RST_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output ctlStrobes_t       strb,
  output logic              swBusy
);

  localparam int CNT_W = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] rstCnt;
  logic             startRst;

  assign startRst = regWrEn && (regAddr == ADDR_CTL) && regWrData[0] && !swBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - 1'b1;
    end else if (startRst) begin
      rstCnt <= CNT_W'(RST_CYC);
    end
  end

  assign swBusy = (rstCnt != '0);

  always_comb begin
    strb.clrAll  = swBusy;
    strb.stsW1c  = regWrEn && !swBusy && (regAddr == ADDR_STS);
    strb.stsEnWr = regWrEn && !swBusy && (regAddr == ADDR_STSEN);
    strb.sigEnWr = regWrEn && !swBusy && (regAddr == ADDR_SIGEN);
  end

  // R8: no register load may be issued while the reset window is open
  assert_no_load_in_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |-> !(strb.stsW1c || strb.stsEnWr || strb.sigEnWr));

endmodule

// File: rtl/sd_irq_dp.sv
module sd_irq_dp
  import sd_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = 32'h000F_003B,
  parameter logic [REG_W-1:0] ERR_MASK  = 32'h000F_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [REG_W-1:0]  wrData,
  input  logic [REG_W-1:0]  evtPulse,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              swBusy,
  output logic [REG_W-1:0]  rdData,
  output logic              irqOut
);

  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] statEnQ;
  logic [REG_W-1:0] sigEnQ;
  logic             errSummary;

  for (genvar b = 0; b < REG_W; b++) begin : g_stsBit
    if (IMPL_MASK[b]) begin : g_impl
      logic bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bitQ <= 1'b0;
        end else if (strb.clrAll) begin
          bitQ <= 1'b0;
        end else if (evtPulse[b] && statEnQ[b]) begin
          bitQ <= 1'b1;
        end else if (strb.stsW1c && wrData[b]) begin
          bitQ <= 1'b0;
        end
      end
      assign statusQ[b] = bitQ;
    end else begin : g_tie
      assign statusQ[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statEnQ <= '0;
      sigEnQ  <= '0;
    end else if (strb.clrAll) begin
      statEnQ <= '0;
      sigEnQ  <= '0;
    end else begin
      if (strb.stsEnWr) statEnQ <= wrData & IMPL_MASK;
      if (strb.sigEnWr) sigEnQ  <= wrData & IMPL_MASK;
    end
  end

  assign errSummary = |(statusQ & ERR_MASK);
  assign irqOut     = |(statusQ & sigEnQ);

  always_comb begin
    unique case (rdAddr)
      ADDR_STS: begin
        rdData          = statusQ;
        rdData[SUM_BIT] = errSummary;
      end
      ADDR_STSEN: rdData = statEnQ;
      ADDR_SIGEN: rdData = sigEnQ;
      default:    rdData = {{(REG_W-1){1'b0}}, swBusy};
    endcase
  end

  assert_sw_reset_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (statusQ == '0 && statEnQ == '0 && sigEnQ == '0));

  assert_latch_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(statEnQ)) == '0));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.stsW1c |=> ((statusQ & $past(wrData & ~evtPulse)) == '0));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stsW1c && ((evtPulse & statEnQ & wrData & IMPL_MASK) != '0))
      |=> ((statusQ & $past(evtPulse & statEnQ & wrData & IMPL_MASK))
           == $past(evtPulse & statEnQ & wrData & IMPL_MASK)));

  assert_irq_needs_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ != '0));

endmodule

// File: rtl/sd_irq_status.sv
module sd_irq_status
  import sd_irq_pkg::*;
#(
  parameter logic [15:0] NORM_MASK = 16'h003B,
  parameter int          ERR_W     = 4,
  parameter int          RST_CYC   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] evtPulse,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irqOut
);

  localparam logic [REG_W-1:0] ERR_MASK  = ((REG_W'(1) << ERR_W) - 1'b1) << ERR_LSB;
  localparam logic [REG_W-1:0] IMPL_MASK = ERR_MASK | {16'h0, NORM_MASK & 16'h7FFF};

  ctlStrobes_t strb;
  logic        swBusy;

  sd_irq_ctrl #(
    .RST_CYC (RST_CYC)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb),
    .swBusy    (swBusy)
  );

  sd_irq_dp #(
    .IMPL_MASK (IMPL_MASK),
    .ERR_MASK  (ERR_MASK)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .evtPulse (evtPulse),
    .rdAddr   (regAddr),
    .swBusy   (swBusy),
    .rdData   (regRdData),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/test_sd_irq_status.sv
module test_sd_irq_status;

  localparam logic [31:0] IMPL = 32'h000F_003B;
  localparam logic [31:0] ERRM = 32'h000F_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtPulse = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expSts = '0, expSe = '0, expSg = '0;

  sd_irq_status i_sd_irq_status (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] stsView(input logic [31:0] s);
    return s | ({31'd0, |(s & ERRM)} << 15);
  endfunction

  // one clock step; model follows the requirements (no reset in progress)
  task automatic step(input logic [31:0] evt, input logic wr, input logic [1:0] a,
                      input logic [31:0] d);
    evtPulse = evt; regWrEn = wr; regAddr = a; regWrData = d;
    @(posedge clk); #2;
    expSts = (expSts & ~((wr && a == 2'd0) ? d : 32'h0)) | (evt & expSe & IMPL);
    if (wr && a == 2'd1) expSe = d & IMPL;
    if (wr && a == 2'd2) expSg = d & IMPL;
    evtPulse = '0; regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] v;
    rd(2'd0, v); check({tag, " status"}, v, stsView(expSts));
    rd(2'd1, v); check({tag, " stsEn"}, v, expSe);
    rd(2'd2, v); check({tag, " sigEn"}, v, expSg);
    check({tag, " irq"}, {31'd0, irqOut}, {31'd0, |(expSts & expSg)});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] lfsr;
    repeat (3) @(posedge clk); #2;
    checkAll("R11 reset");
    rstN = 1'b1;
    @(posedge clk); #2;

    // R1 R2 R4 R5 R10: every bit, every enable combination
    for (int b = 0; b < 32; b++) begin
      for (int m = 0; m < 4; m++) begin
        step('0, 1'b1, 2'd1, (m[0] ? 32'h1 << b : 32'h0));
        step('0, 1'b1, 2'd2, (m[1] ? 32'h1 << b : 32'h0));
        step(32'h1 << b, 1'b0, 2'd0, '0);
        checkAll("R1 R2 R4 R5 R10 sweep");
        rd(2'd0, v);
        step('0, 1'b1, 2'd0, v);
        checkAll("R3 clear-by-readback");
      end
    end

    // R4: latched bit survives enable removal
    step('0, 1'b1, 2'd1, 32'h0001_0002);
    step(32'h0001_0002, 1'b0, 2'd0, '0);
    step('0, 1'b1, 2'd1, 32'h0);
    checkAll("R4 latched after enable drop");

    // R6: bit 15 not clearable while an error bit is set
    step('0, 1'b1, 2'd0, 32'h0000_8000);
    rd(2'd0, v); check("R6 summary kept", v, 32'h0001_8002);
    step('0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    step(32'h0000_8000, 1'b0, 2'd0, '0);
    rd(2'd0, v); check("R6 event 15 ignored", v, 32'h0001_8002);
    step('0, 1'b1, 2'd0, 32'h0001_0000);
    rd(2'd0, v); check("R2 summary falls", v, 32'h0000_0002);
    step('0, 1'b1, 2'd0, 32'hFFFF_FFFF);

    // R7: event and clear of the same bit in one cycle
    step(32'h0008_0001, 1'b0, 2'd0, '0);
    step(32'h0000_0001, 1'b1, 2'd0, 32'h0008_0001);
    rd(2'd0, v); check("R7 event beats clear", v, 32'h0000_0001);
    checkAll("R7 collision");

    // R3 R5: pseudo-random multi-bit patterns
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step('0, 1'b1, 2'd2, lfsr ^ 32'h5A5A_5A5A);
      step(lfsr, 1'b0, 2'd0, '0);
      step(lfsr >> 3, 1'b1, 2'd0, {lfsr[15:0], lfsr[31:16]});
      checkAll("R3 R5 random");
    end

    // R8 R9: software reset window
    step('0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    step('0, 1'b1, 2'd2, 32'hFFFF_FFFF);
    step(32'hFFFF_FFFF, 1'b0, 2'd0, '0);
    step('0, 1'b1, 2'd3, 32'h1);
    expSts = '0; expSe = '0; expSg = '0;
    for (int c = 0; c < 8; c++) begin
      rd(2'd3, v); check("R9 busy during window", v, 32'h1);
      evtPulse = 32'hFFFF_FFFF; regWrEn = 1'b1;
      regAddr = (c % 2 == 0) ? 2'd1 : 2'd2; regWrData = 32'hFFFF_FFFF;
      @(posedge clk); #2;
      evtPulse = '0; regWrEn = 1'b0; regWrData = '0;
    end
    rd(2'd3, v); check("R9 self-clear after 8", v, 32'h0);
    checkAll("R8 cleared after reset");
    step(32'h0000_0001, 1'b0, 2'd0, '0);
    checkAll("R8 enables stay off");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule